// File: doc/BRIEF.md
# CRC-8 Barrett Remainder Unit

This unit turns a 16-bit folded value into its 8-bit CRC. The CRC is the remainder of the value, shifted up by eight bit positions, divided by the generator x^8 + x^2 + x + 1 (0x107) in carryless (GF(2)) arithmetic. It uses no bit-serial divider. The upper byte is first moved onto the lower half with one carryless product against the constant x^16 mod P. A quotient is then estimated from the precomputed inverse floor(x^16 / P). That quotient, multiplied back by the low part of the generator, cancels everything except the remainder.

The unit sits at the end of a wider folding CRC engine. Many partial products are XOR-ed into one 16-bit fold value, and this unit performs the single reduction at the end. Each cycle it accepts one value qualified by a valid strobe and returns the CRC with its own valid strobe. By default the result is registered, one cycle after the input. A parameter selects a purely combinational variant. The generator, and with it every derived constant, is a parameter.

Top module: `crc8_barrett`

## Requirements
- R1: For every 16-bit input value V, the CRC output equals (V · x^8) mod 0x107 in carryless arithmetic, with the input bit 15 weighted as x^15.
- R2: Input 0xFFFE gives CRC 0x23, and input 0x1137 gives CRC 0xC7.
- R3: The CRC is linear over XOR: crc(A xor B) = crc(A) xor crc(B) for any two inputs.
- R4: Input 0x0000 gives CRC 0x00.
- R5: With the default registered variant, the output valid equals the input valid of the previous clock cycle, and the CRC of an accepted value is present in that same cycle.
- R6: While the synchronous active-high reset is sampled high, the next cycle shows output valid 0 and CRC 0x00, whatever the input valid is.
- R7: In a cycle where the input valid is low, the input value is ignored and the CRC output keeps its previous value in the following cycle.
- R8: A single set input bit k (V = 1 << k, k = 0..15) gives x^(k+8) mod 0x107.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input value qualifier |
| in_fold | input | 16 | Folded value to reduce (2·CRC_W bits) |
| out_valid | output | 1 | Result qualifier |
| out_crc | output | 8 | CRC remainder (CRC_W bits) |

## Verification
The bench sweeps all 65536 input values back to back. It compares each result with a shift-and-subtract remainder that it computes itself. A wrong fold constant, a wrong inverse or a wrong cancel step therefore shows up on some input. Single-bit inputs separate a fault in one partial-product lane from a fault in the rest of the arithmetic. The two values with known answers pin the exact numbers, and XOR pairs over the stored results expose any nonlinear slip. Short directed sequences, with the valid strobe low and with reset asserted during a valid input, tell the hold behaviour apart from the capture behaviour.

// File: rtl/crc_barrett_pkg.sv
package crc_barrett_pkg;

  localparam int MAXW = 32;

  // x^n mod poly, poly given with its degree-w term included
  function automatic logic [MAXW-1:0] xpow_mod(int n, logic [MAXW:0] poly, int w);
    logic [MAXW:0] r;
    r = '0;
    r[0] = 1'b1;
    for (int i = 0; i < n; i++) begin
      r = r << 1;
      if (r[w]) r = r ^ poly;
    end
    return r[MAXW-1:0];
  endfunction

  // floor(x^(2w) / poly): the Barrett inverse, degree w
  function automatic logic [MAXW:0] xdiv_inv(int w, logic [MAXW:0] poly);
    logic [MAXW:0] r;
    logic [MAXW:0] q;
    r = '0;
    r[0] = 1'b1;
    q = '0;
    for (int i = 0; i < 2 * w; i++) begin
      r = r << 1;
      q = q << 1;
      if (r[w]) begin
        q[0] = 1'b1;
        r = r ^ poly;
      end
    end
    return q;
  endfunction

endpackage

// File: rtl/crc_clmul.sv
module crc_clmul #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int PW = AW + BW - 1
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [PW-1:0] p
);

  localparam int EXT = (PW > BW) ? PW : BW;

  logic [EXT-1:0] b_ext;
  logic [PW-1:0]  lane [AW];

  assign b_ext = EXT'(b);

  generate
    for (genvar g = 0; g < AW; g++) begin : g_lane
      logic [EXT-1:0] sh;
      assign sh      = b_ext << g;
      assign lane[g] = a[g] ? sh[PW-1:0] : '0;
    end
  endgenerate

  always_comb begin
    p = '0;
    for (int i = 0; i < AW; i++) p = p ^ lane[i];
  end

endmodule

// File: rtl/crc_barrett_fold.sv
module crc_barrett_fold #(
  parameter int          W = 8,
  parameter logic [W-1:0] K = 8'h15
) (
  input  logic [2*W-1:0] v,
  output logic [2*W-1:0] u
);

  logic [2*W-2:0] hi_moved;

  crc_clmul #(.AW(W), .BW(W), .PW(2*W-1)) u_mul (
    .a (v[2*W-1:W]),
    .b (K),
    .p (hi_moved)
  );

  assign u = {1'b0, hi_moved} ^ {v[W-1:0], {W{1'b0}}};

endmodule

// File: rtl/crc_barrett_reduce.sv
module crc_barrett_reduce #(
  parameter int           W       = 8,
  parameter logic [W-1:0] INV_LO  = 8'h07,
  parameter logic [W-1:0] POLY_LO = 8'h07
) (
  input  logic [2*W-1:0] u,
  output logic [W-1:0]   rem
);

  logic [2*W-2:0] est;
  logic [W-1:0]   quo;
  logic [W-1:0]   back;

  // upper half times the inverse; the implicit x^W term of the inverse is u_hi itself
  crc_clmul #(.AW(W), .BW(W), .PW(2*W-1)) u_est (
    .a (u[2*W-1:W]),
    .b (INV_LO),
    .p (est)
  );

  assign quo = u[2*W-1:W] ^ {1'b0, est[2*W-2:W]};

  // only the low half of quotient * poly survives the cancel
  crc_clmul #(.AW(W), .BW(W), .PW(W)) u_back (
    .a (quo),
    .b (POLY_LO),
    .p (back)
  );

  assign rem = u[W-1:0] ^ back;

endmodule

// File: rtl/crc8_barrett.sv
module crc8_barrett
  import crc_barrett_pkg::*;
#(
  parameter int               CRC_W      = 8,
  parameter logic [CRC_W:0]   POLY       = 9'h107,
  parameter bit               REGISTERED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2*CRC_W-1:0]   in_fold,
  output logic                 out_valid,
  output logic [CRC_W-1:0]     out_crc
);

  localparam logic [MAXW:0]    POLY_X  = (MAXW+1)'(POLY);
  localparam logic [MAXW-1:0]  FOLD_X  = xpow_mod(2 * CRC_W, POLY_X, CRC_W);
  localparam logic [MAXW:0]    INV_X   = xdiv_inv(CRC_W, POLY_X);
  localparam logic [CRC_W-1:0] FOLD_K  = FOLD_X[CRC_W-1:0];
  localparam logic [CRC_W-1:0] INV_LO  = INV_X[CRC_W-1:0];
  localparam logic [CRC_W-1:0] POLY_LO = POLY[CRC_W-1:0];

  logic [2*CRC_W-1:0] folded;
  logic [CRC_W-1:0]   rem;

  crc_barrett_fold #(.W(CRC_W), .K(FOLD_K)) u_fold (
    .v (in_fold),
    .u (folded)
  );

  crc_barrett_reduce #(.W(CRC_W), .INV_LO(INV_LO), .POLY_LO(POLY_LO)) u_reduce (
    .u   (folded),
    .rem (rem)
  );

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_crc   <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_crc <= rem;
        end
      end

      // R5
      a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      a_r5_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      // R7
      a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_crc));
      // R4
      a_r4_zero_in: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fold == '0) |=> (out_crc == '0));
      // R6
      a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_crc == '0));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_crc   = rem;
    end
  endgenerate

endmodule

// File: tb/crc8_barrett_bench.sv
module crc8_barrett_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_fold = '0;
  logic        out_valid;
  logic [7:0]  out_crc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] obs [65536];

  always #5 clk = ~clk;

  crc8_barrett u_crc8_barrett (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_fold   (in_fold),
    .out_valid (out_valid),
    .out_crc   (out_crc)
  );

  // shift-and-subtract remainder of (v * x^8) by 0x107
  function automatic logic [7:0] ref_crc(logic [15:0] v);
    logic [23:0] d;
    d = {v, 8'h00};
    for (int b = 23; b >= 8; b--)
      if (d[b]) d = d ^ (24'h000107 << (b - 8));
    return d[7:0];
  endfunction

  function automatic logic [7:0] xpow(int n);
    logic [8:0] r;
    r = 9'h001;
    for (int i = 0; i < n; i++) begin
      r = r << 1;
      if (r[8]) r = r ^ 9'h107;
    end
    return r[7:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic vld, logic [15:0] v);
    @(negedge clk);
    in_valid = vld;
    in_fold  = v;
    @(negedge clk);
  endtask

  initial begin
    // R6: reset held while a valid value is offered
    in_valid = 1'b1;
    in_fold  = 16'hFFFE;
    repeat (3) @(negedge clk);
    check("R6 valid in reset", 16'(out_valid), 16'h0);
    check("R6 crc in reset", 16'(out_crc), 16'h00);
    in_valid = 1'b0;
    rst = 1'b0;

    // R2, R5
    put(1'b1, 16'hFFFE);
    check("R5 valid after accept", 16'(out_valid), 16'h1);
    check("R2 crc of FFFE", 16'(out_crc), 16'h23);
    // R7: invalid value ignored, crc held
    put(1'b0, 16'h1137);
    check("R5 valid drops", 16'(out_valid), 16'h0);
    check("R7 crc held", 16'(out_crc), 16'h23);
    put(1'b1, 16'h1137);
    check("R2 crc of 1137", 16'(out_crc), 16'hC7);
    put(1'b1, 16'h0000);
    check("R4 zero input", 16'(out_crc), 16'h00);

    // R8: single-bit inputs
    for (int k = 0; k < 16; k++) begin
      put(1'b1, 16'(1) << k);
      check("R8 single bit", 16'(out_crc), 16'(xpow(k + 8)));
    end

    // R1: exhaustive, back to back
    for (int i = 0; i <= 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        obs[i-1] = out_crc;
        check("R1 sweep", 16'(out_crc), 16'(ref_crc(16'(i - 1))));
      end
      in_valid = (i < 65536);
      in_fold  = 16'(i);
    end

    // R3: XOR linearity over observed results
    for (int j = 0; j < 256; j++) begin
      logic [15:0] a;
      logic [15:0] b;
      a = 16'(j * 40503);
      b = 16'(j * 12345 + 7);
      check("R3 linearity", 16'(obs[a ^ b]), 16'(obs[a] ^ obs[b]));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule